// File: doc/BRIEF.md
# Serial Port With Register Access

This peripheral moves bytes between a processor and a serial line. Software controls it through three 16-bit registers, chosen by a two-bit address: a rate selector, a combined status and interrupt-mask register, and a data register. Every frame is one low start bit, eight data bits sent least significant bit first, one odd parity bit and one high stop bit.

All timing comes from a fractional prescaler that divides the system clock by 13.5. It does this by alternating periods of 13 and 14 clocks. A second divider then divides by N+1, where N is the 4-bit rate value. The result is a tick at sixteen times the bit rate. The receiver finds the falling edge of a start bit and samples each bit on the eighth tick. It then reports the byte together with parity, framing and overrun flags. Any status flag that software has left unmasked drives the interrupt request.

Top module: `serial_port_regs`

## Requirements
- R1: After reset, the rate register reads 12, all five interrupt sources are masked, the status register reads 0x4000 (only transmit-ready is set), the interrupt request is low and the serial output is high.
- R2: At address 0, bits 3..0 of a write set N. Each bit then lasts 13.5 × 16 × (N+1) clocks. Because the first oversampling period of a frame can be partial, a start bit lasts between 15/16 and 16/16 of that.
- R3: A transmitted frame is a low start bit, data bits 0..7 in that order, a parity bit that makes the count of ones in data and parity odd, and a high stop bit. The line is high whenever no frame is being sent.
- R4: A write to the data register (address 2) clears transmit-ready (status bit 14) while the frame is being sent, and sets it again once the stop bit has ended. A data write made while transmit-ready is low is dropped.
- R5: A read of the data register returns the last received byte in bits 7..0, with bit 7 copied into bits 15..8. The same read clears receive-ready (status bit 15).
- R6: A received frame whose data and parity bits hold an even number of ones sets parity-error (status bit 13). The byte is still delivered.
- R7: A received frame whose stop bit is sampled low sets framing-error (status bit 12). The receiver does not look for the next start bit until the line has returned high.
- R8: If a frame completes while receive-ready is still set, overrun (status bit 11) is set and the byte is replaced by the new one. A read of the data register clears the parity, framing and overrun flags.
- R9: A low pulse on the receive line that no longer holds at the mid-bit sample of the start bit is dropped. It sets no flag and delivers no byte.
- R10: Reading the status register at address 1 gives the five flags in bits 15..11. Writing it stores bits 15..11 as per-flag interrupt masks, where 1 means masked. The interrupt request is high exactly while some flag is set and its mask bit is 0.
- R11: Unused register bits read as 0: bits 15..4 at address 0, bits 10..0 at address 1, and the whole word at address 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register select: 0 rate, 1 status/mask, 2 data |
| rd | input | 1 | Read strobe (side effects on the clock edge) |
| wr | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rxd | input | 1 | Serial receive line |
| rdata | output | 16 | Read data for the addressed register (combinational) |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request |

## Verification
Two conditions are hard to reach from the ports. The first is overrun, which needs a second full frame to finish before software has read the first. The bench drives two back-to-back frames with no read between them, then checks that the second byte is the one returned. The second is the 13/14 prescaler alternation, which only shows up in the length of a bit. The bench sends a byte whose first data bit is 1, so the start bit is an isolated low pulse, and counts its width in clocks at two rate settings. A short low glitch and a forced low stop bit, followed by a return to idle, cover the receiver's rejection and re-arming paths.

// File: rtl/serial_port_regs.sv
module serial_port_regs #(
  parameter int REG_W      = 16,
  parameter int BAUD_W     = 4,
  parameter int BAUD_RST   = 12,
  parameter int PRE_SHORT  = 13,
  parameter int OVERSAMPLE = 16,
  parameter int SAMPLE_PT  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             rd,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             rxd,
  output logic [REG_W-1:0] rdata,
  output logic             txd,
  output logic             irq
);
  localparam int NSTAT      = 5;
  localparam int ST_LO      = REG_W - NSTAT;
  localparam int FRAME_BITS = 11;
  localparam int PRE_W      = $clog2(PRE_SHORT + 2);
  localparam int OS_W       = $clog2(OVERSAMPLE);
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam logic [OS_W-1:0]  OS_LAST = OS_W'(OVERSAMPLE - 1);
  localparam logic [OS_W-1:0]  OS_MID  = OS_W'(SAMPLE_PT);
  localparam logic [IDX_W-1:0] LAST_IX = IDX_W'(FRAME_BITS - 1);

  logic [PRE_W-1:0]  pre_cnt;
  logic              pre_long, pre_tick, os_tick;
  logic [BAUD_W-1:0] div_cnt, baud;
  logic [NSTAT-1:0]  mask, stat;
  logic              rxrdy, perr, ferr, ovr;
  logic [7:0]        rx_byte;
  logic              tx_busy;
  logic [9:0]        tx_sh;
  logic [IDX_W-1:0]  tx_idx, rx_idx;
  logic [OS_W-1:0]   tx_os, rx_os;
  logic              rx_s1, rx_s2, rx_busy, rx_armed, rx_done, rx_samp;
  logic [8:0]        rx_sh;

  wire wr_baud = wr && addr == 2'd0;
  wire wr_mask = wr && addr == 2'd1;
  wire wr_dat  = wr && addr == 2'd2;
  wire rd_dat  = rd && addr == 2'd2;

  assign pre_tick = pre_cnt == (pre_long ? PRE_W'(PRE_SHORT) : PRE_W'(PRE_SHORT - 1));
  assign os_tick  = pre_tick && div_cnt == baud;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      pre_long <= 1'b0;
      div_cnt  <= '0;
    end else begin
      if (pre_tick) begin
        pre_cnt  <= '0;
        pre_long <= ~pre_long;
        div_cnt  <= os_tick ? '0 : div_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baud <= BAUD_W'(BAUD_RST);
      mask <= '1;
    end else begin
      if (wr_baud) baud <= wdata[BAUD_W-1:0];
      if (wr_mask) mask <= wdata[REG_W-1:ST_LO];
    end
  end

  assign stat = {rxrdy, ~tx_busy, perr, ferr, ovr};
  assign irq  = |(stat & ~mask);

  always_comb begin
    case (addr)
      2'd0:    rdata = {{(REG_W-BAUD_W){1'b0}}, baud};
      2'd1:    rdata = {stat, {ST_LO{1'b0}}};
      2'd2:    rdata = {{(REG_W-8){rx_byte[7]}}, rx_byte};
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      txd     <= 1'b1;
      tx_sh   <= '1;
      tx_idx  <= '0;
      tx_os   <= '0;
    end else if (wr_dat && !tx_busy) begin
      tx_busy <= 1'b1;
      txd     <= 1'b0;
      tx_sh   <= {1'b1, ~^wdata[7:0], wdata[7:0]};
      tx_idx  <= '0;
      tx_os   <= '0;
    end else if (tx_busy && os_tick) begin
      if (tx_os == OS_LAST) begin
        tx_os <= '0;
        if (tx_idx == LAST_IX) begin
          tx_busy <= 1'b0;
          txd     <= 1'b1;
        end else begin
          txd    <= tx_sh[0];
          tx_sh  <= {1'b1, tx_sh[9:1]};
          tx_idx <= tx_idx + 1'b1;
        end
      end else begin
        tx_os <= tx_os + 1'b1;
      end
    end
  end

  assign rx_samp = rx_busy && os_tick && rx_os == OS_MID;
  assign rx_done = rx_samp && rx_idx == LAST_IX;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_s1    <= 1'b1;
      rx_s2    <= 1'b1;
      rx_busy  <= 1'b0;
      rx_armed <= 1'b0;
      rx_idx   <= '0;
      rx_os    <= '0;
      rx_sh    <= '0;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
      if (!rx_busy) begin
        if (rx_s2) begin
          rx_armed <= 1'b1;
        end else if (rx_armed) begin
          rx_busy <= 1'b1;
          rx_idx  <= '0;
          rx_os   <= '0;
        end
      end else if (os_tick) begin
        rx_os <= (rx_os == OS_LAST) ? '0 : rx_os + 1'b1;
        if (rx_samp) begin
          if (rx_idx == '0) begin
            if (rx_s2) rx_busy <= 1'b0;
            else       rx_idx  <= rx_idx + 1'b1;
          end else if (rx_idx == LAST_IX) begin
            rx_busy  <= 1'b0;
            rx_armed <= 1'b0;
          end else begin
            rx_sh  <= {rx_s2, rx_sh[8:1]};
            rx_idx <= rx_idx + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxrdy   <= 1'b0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
      ovr     <= 1'b0;
      rx_byte <= '0;
    end else if (rx_done) begin
      rx_byte <= rx_sh[7:0];
      rxrdy   <= 1'b1;
      perr    <= ~^rx_sh;
      ferr    <= ~rx_s2;
      ovr     <= (ovr || rxrdy) && !rd_dat;
    end else if (rd_dat) begin
      rxrdy <= 1'b0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
      ovr   <= 1'b0;
    end
  end
endmodule

module serial_port_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  addr,
  input logic [15:0] rdata,
  input logic        wr_dat,
  input logic        rd_dat,
  input logic        tx_busy,
  input logic        txd,
  input logic        rxrdy,
  input logic        ovr,
  input logic        rx_done,
  input logic [4:0]  mask,
  input logic        irq
);
  // R4
  tx_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat && !tx_busy |=> tx_busy);
  // R3
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  // R5
  rx_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dat && !rx_done |=> !rxrdy);
  // R8
  ovr_on_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rxrdy && !rd_dat |=> ovr);
  // R10
  irq_all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);
  // R11
  baud_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 2'd0 |-> rdata[15:4] == 12'd0);
endmodule

bind serial_port_regs serial_port_regs_chk i_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rdata(rdata),
  .wr_dat(wr_dat), .rd_dat(rd_dat), .tx_busy(tx_busy), .txd(txd),
  .rxrdy(rxrdy), .ovr(ovr), .rx_done(rx_done), .mask(mask), .irq(irq)
);

// File: tb/test_serial_port_regs.sv
module test_serial_port_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [15:0] wdata = '0;
  logic        rxd = 1'b1;
  logic [15:0] rdata;
  logic        txd, irq;

  int errors = 0, checks = 0;
  bit finished = 0;
  int bitclk = 216;

  serial_port_regs i_serial_port_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rxd(rxd), .rdata(rdata), .txd(txd), .irq(irq)
  );

  always #5 clk = ~clk;

  // {byte, bad parity, bad stop}
  localparam logic [9:0] VEC [8] = '{
    {8'h55, 1'b0, 1'b0}, {8'hA3, 1'b0, 1'b0}, {8'h00, 1'b0, 1'b0},
    {8'hFF, 1'b0, 1'b0}, {8'h81, 1'b1, 1'b0}, {8'h7E, 1'b0, 1'b1},
    {8'hC4, 1'b1, 1'b1}, {8'h19, 1'b0, 1'b0}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b, input logic bad_par, input logic bad_stop);
    logic [10:0] fr;
    fr = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rxd = fr[i];
      repeat (bitclk) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic cap_tx(output logic [7:0] b, output logic par, output logic stp);
    int t;
    t = 0;
    while (txd && t < 5000) begin @(negedge clk); t++; end
    repeat (bitclk / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (bitclk) @(negedge clk);
      b[i] = txd;
    end
    repeat (bitclk) @(negedge clk); par = txd;
    repeat (bitclk) @(negedge clk); stp = txd;
  endtask

  task automatic start_len(output int n);
    n = 0;
    while (txd) @(negedge clk);
    while (!txd && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [7:0] b;
    logic p, s;
    int n;
    bit hi;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R11 unused bits
    rd_reg(2'd0, d); chk("R1 baud reset", d, 16'd12);
    rd_reg(2'd1, d); chk("R1 status reset", d, 16'h4000);
    chk("R1 irq reset", irq, 0);
    chk("R1 txd idle", txd, 1);
    rd_reg(2'd3, d); chk("R11 addr3 zero", d, 0);
    // R2 only low bits kept
    wr_reg(2'd0, 16'hFFF0);
    rd_reg(2'd0, d); chk("R2 baud write", d, 0);

    foreach (VEC[k]) begin
      send_rx(VEC[k][9:2], VEC[k][1], VEC[k][0]);
      rd_reg(2'd1, d);
      chk("R6 R7 status after frame", d, 16'hC000 | (VEC[k][1] << 13) | (VEC[k][0] << 12));
      rd_reg(2'd2, d);
      chk("R5 rx byte", d, {{8{VEC[k][9]}}, VEC[k][9:2]});
      rd_reg(2'd1, d); chk("R8 flags cleared by read", d, 16'h4000);
      wr_reg(2'd2, {8'h00, VEC[k][9:2]});
      rd_reg(2'd1, d); chk("R4 txrdy low while sending", d, 16'h0000);
      cap_tx(b, p, s);
      chk("R3 tx data", b, VEC[k][9:2]);
      chk("R3 tx odd parity", ^{b, p}, 1);
      chk("R3 tx stop", s, 1);
      repeat (bitclk) @(negedge clk);
      rd_reg(2'd1, d); chk("R4 txrdy after frame", d, 16'h4000);
    end

    // R8 overrun
    send_rx(8'h11, 0, 0);
    send_rx(8'h92, 0, 0);
    rd_reg(2'd1, d); chk("R8 overrun set", d, 16'hC800);
    rd_reg(2'd2, d); chk("R8 newest byte kept", d, 16'hFF92);
    rd_reg(2'd1, d); chk("R8 overrun cleared", d, 16'h4000);

    // R9 glitch
    rxd = 1'b0; repeat (50) @(negedge clk); rxd = 1'b1;
    repeat (600) @(negedge clk);
    rd_reg(2'd1, d); chk("R9 glitch ignored", d, 16'h4000);

    // R10 masking
    send_rx(8'h3C, 0, 0);
    chk("R10 irq masked", irq, 0);
    wr_reg(2'd1, 16'h7800);
    #1 chk("R10 rxrdy unmasked irq", irq, 1);
    rd_reg(2'd2, d);
    #1 chk("R10 irq drops after read", irq, 0);
    wr_reg(2'd1, 16'hB800);
    #1 chk("R10 txrdy unmasked irq", irq, 1);
    wr_reg(2'd1, 16'hF800);
    #1 chk("R10 all masked", irq, 0);

    // R4 write while busy dropped
    wr_reg(2'd2, 16'h00A5);
    wr_reg(2'd2, 16'h003C);
    cap_tx(b, p, s);
    chk("R4 first byte sent", b, 8'hA5);
    hi = 1;
    repeat (3 * bitclk) begin @(negedge clk); if (!txd) hi = 0; end
    chk("R4 busy write dropped", hi, 1);

    // R2 bit timing
    wr_reg(2'd2, 16'h0001);
    start_len(n);
    chk("R2 start len N=0", (n >= 198 && n <= 220), 1);
    repeat (12 * bitclk) @(negedge clk);
    wr_reg(2'd0, 16'h0001);
    bitclk = 432;
    wr_reg(2'd2, 16'h0001);
    start_len(n);
    chk("R2 start len N=1", (n >= 400 && n <= 440), 1);
    repeat (12 * bitclk) @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule